// File: doc/BRIEF.md
# PCI Configuration Address and Data Port Pair

This block sits in a PCI host bridge and gives software two 32-bit registers in an eight-byte window. Offset 0 is the configuration address port and offset 4 is the configuration data port. Software first writes a target address into the address port. It then reads or writes the data port, and each such access becomes one configuration request towards a downstream completer. The request carries the bus, device, function and register number decoded from the stored address, plus byte enables and write data.

The address port tolerates careless software. A write of the wrong size, or a write at the wrong offset, is dropped. The two lowest bits of an accepted value are cleared, and the enable bit is forced on no matter what was written. Both ports are little-endian, and host data sits on its natural byte lanes.

The host side is a single-cycle request with a one-cycle-registered response. While a data-port request is in flight, the block reports itself not ready.

Top module: `pci_cfg_port`

## Requirements
- R1: After reset the stored address is zero, `hostReady` is 1, and neither `cfgReqValid` nor `hostRspValid` is asserted.
- R2: A write to the address window (`hostAddr[2]`=0) updates the stored address only when `hostAddr[1:0]`=0 and the size code is a 4-byte code (2 or 3); any other such write leaves it unchanged. The write is still answered, with data 0.
- R3: An accepted address write stores the write data with bits 1:0 forced to 0 and bit 31 forced to 1.
- R4: A read at any offset 0 to 3 returns the stored 32-bit value exactly, with `hostRspValid` high in the cycle after the access.
- R5: A data-port request carries the bus number from stored bits 23:16, the device from 15:11, the function from 10:8 and the register from 7:2.
- R6: Byte enables use a base mask of 0001 (size code 0), 0011 (code 1) or 1111 (codes 2 and 3). The mask is shifted left by `hostAddr[1:0]` and truncated to 4 bits.
- R7: A data-port access (`hostAddr[2]`=1) raises `cfgReqValid` once. The line holds until `cfgRspValid` and then drops. A write passes `hostWdata` unchanged, and the host response follows one cycle after the completer's response, with data 0 for a write.
- R8: A data-port read returns the completer's `cfgRspData` on `hostRdata`.
- R9: `hostReady` is low from the cycle after a data-port access until the completer responds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostValid | input | 1 | Host access strobe, honoured while hostReady is high |
| hostWrite | input | 1 | 1 for write, 0 for read |
| hostAddr | input | 3 | Byte offset within the eight-byte window |
| hostSize | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| hostWdata | input | 32 | Host write data on natural byte lanes |
| hostReady | output | 1 | Block can accept an access |
| hostRspValid | output | 1 | Response strobe |
| hostRdata | output | 32 | Response data |
| cfgReqValid | output | 1 | Configuration request pending |
| cfgWrite | output | 1 | Request is a write |
| cfgBus | output | 8 | Target bus number |
| cfgDev | output | 5 | Target device number |
| cfgFunc | output | 3 | Target function number |
| cfgReg | output | 6 | Target dword register number |
| cfgByteEn | output | 4 | Byte lane enables |
| cfgWdata | output | 32 | Write data to the completer |
| cfgRspValid | input | 1 | Completer response strobe |
| cfgRspData | input | 32 | Completer read data |

## Verification
The assertions check on every cycle:
- the stored address only changes on an accepted write;
- any nonzero stored value has bit 31 set and bits 1:0 clear;
- a pending request stays up until the completer answers;
- byte enables are never empty;
- the block is busy right after a launch.

Only the bench scenarios can show the exact sanitized values, and that each dropped write variant leaves the readback unchanged. The same holds for the field split of specific addresses, the shifted byte enables for each size and offset, and the completer data reaching the host.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
  localparam int HOST_AW  = 3;
  localparam int DATA_W   = 32;
  localparam int BE_W     = DATA_W / 8;
  localparam int BUS_W    = 8;
  localparam int DEV_W    = 5;
  localparam int FN_W     = 3;
  localparam int REG_W    = 6;
  localparam int ENA_BIT  = DATA_W - 1;
  localparam int REG_LSB  = 2;
  localparam int FN_LSB   = REG_LSB + REG_W;
  localparam int DEV_LSB  = FN_LSB + FN_W;
  localparam int BUS_LSB  = DEV_LSB + DEV_W;
  localparam int PORT_SEL = 2;

  typedef struct packed {
    logic latchAddr;
    logic readAddr;
    logic launch;
    logic complete;
  } strobe_t;
endpackage

// File: rtl/pcicfg_ctrl.sv
module pcicfg_ctrl
  import pcicfg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostValid,
  input  logic               hostWrite,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [1:0]         hostSize,
  input  logic               cfgRspValid,
  output strobe_t            stb,
  output logic               hostReady,
  output logic               hostRspValid,
  output logic               cfgReqValid
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_e;
  state_e state;

  logic accept;
  logic dataPort;
  logic wordAligned;

  assign hostReady   = (state == ST_IDLE);
  assign accept      = hostValid && hostReady;
  assign dataPort    = hostAddr[PORT_SEL];
  assign wordAligned = (hostAddr[PORT_SEL-1:0] == '0) && hostSize[1];

  always_comb begin
    stb.latchAddr = accept && hostWrite && !dataPort && wordAligned;
    stb.readAddr  = accept && !hostWrite && !dataPort;
    stb.launch    = accept && dataPort;
    stb.complete  = (state == ST_WAIT) && cfgRspValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      hostRspValid <= 1'b0;
      cfgReqValid  <= 1'b0;
    end else begin
      hostRspValid <= (accept && !dataPort) || stb.complete;
      if (stb.launch) begin
        state       <= ST_WAIT;
        cfgReqValid <= 1'b1;
      end else if (stb.complete) begin
        state       <= ST_IDLE;
        cfgReqValid <= 1'b0;
      end
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgReqValid && !cfgRspValid |=> cfgReqValid);

  // R9
  busy_after_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostValid && hostReady && dataPort |=> !hostReady);

  // R4
  addr_rsp_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostValid && hostReady && !dataPort |=> hostRspValid);
endmodule

// File: rtl/pcicfg_dp.sv
module pcicfg_dp
  import pcicfg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic               hostWrite,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [1:0]         hostSize,
  input  logic [DATA_W-1:0]  hostWdata,
  input  logic [DATA_W-1:0]  cfgRspData,
  output logic [DATA_W-1:0]  hostRdata,
  output logic               cfgWrite,
  output logic [BUS_W-1:0]   cfgBus,
  output logic [DEV_W-1:0]   cfgDev,
  output logic [FN_W-1:0]    cfgFunc,
  output logic [REG_W-1:0]   cfgReg,
  output logic [BE_W-1:0]    cfgByteEn,
  output logic [DATA_W-1:0]  cfgWdata
);
  logic [DATA_W-1:0]  addrReg;
  logic [DATA_W-1:0]  cleanVal;
  logic [BE_W-1:0]    baseMask;
  logic [2*BE_W-1:0]  shiftedMask;

  always_comb begin
    cleanVal = hostWdata;
    cleanVal[REG_LSB-1:0] = '0;
    cleanVal[ENA_BIT] = 1'b1;
  end

  always_comb begin
    case (hostSize)
      2'd0:    baseMask = BE_W'(1);
      2'd1:    baseMask = BE_W'(3);
      default: baseMask = '1;
    endcase
    shiftedMask = {{BE_W{1'b0}}, baseMask} << hostAddr[PORT_SEL-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (stb.latchAddr) begin
      addrReg <= cleanVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdata <= '0;
    end else if (stb.readAddr) begin
      hostRdata <= addrReg;
    end else if (stb.complete && !cfgWrite) begin
      hostRdata <= cfgRspData;
    end else begin
      hostRdata <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgWrite  <= 1'b0;
      cfgBus    <= '0;
      cfgDev    <= '0;
      cfgFunc   <= '0;
      cfgReg    <= '0;
      cfgByteEn <= '0;
      cfgWdata  <= '0;
    end else if (stb.launch) begin
      cfgWrite  <= hostWrite;
      cfgBus    <= addrReg[BUS_LSB +: BUS_W];
      cfgDev    <= addrReg[DEV_LSB +: DEV_W];
      cfgFunc   <= addrReg[FN_LSB +: FN_W];
      cfgReg    <= addrReg[REG_LSB +: REG_W];
      cfgByteEn <= shiftedMask[BE_W-1:0];
      cfgWdata  <= hostWdata;
    end
  end

  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latchAddr |=> $stable(addrReg));

  // R3
  addr_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrReg != '0) |-> (addrReg[ENA_BIT] && addrReg[REG_LSB-1:0] == '0));

  // R6
  be_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.launch |=> $countones(cfgByteEn) >= 1);
endmodule

// File: rtl/pci_cfg_port.sv
module pci_cfg_port
  import pcicfg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostValid,
  input  logic               hostWrite,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [1:0]         hostSize,
  input  logic [DATA_W-1:0]  hostWdata,
  output logic               hostReady,
  output logic               hostRspValid,
  output logic [DATA_W-1:0]  hostRdata,
  output logic               cfgReqValid,
  output logic               cfgWrite,
  output logic [BUS_W-1:0]   cfgBus,
  output logic [DEV_W-1:0]   cfgDev,
  output logic [FN_W-1:0]    cfgFunc,
  output logic [REG_W-1:0]   cfgReg,
  output logic [BE_W-1:0]    cfgByteEn,
  output logic [DATA_W-1:0]  cfgWdata,
  input  logic               cfgRspValid,
  input  logic [DATA_W-1:0]  cfgRspData
);
  strobe_t stb;

  pcicfg_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .hostValid   (hostValid),
    .hostWrite   (hostWrite),
    .hostAddr    (hostAddr),
    .hostSize    (hostSize),
    .cfgRspValid (cfgRspValid),
    .stb         (stb),
    .hostReady   (hostReady),
    .hostRspValid(hostRspValid),
    .cfgReqValid (cfgReqValid)
  );

  pcicfg_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .hostWrite (hostWrite),
    .hostAddr  (hostAddr),
    .hostSize  (hostSize),
    .hostWdata (hostWdata),
    .cfgRspData(cfgRspData),
    .hostRdata (hostRdata),
    .cfgWrite  (cfgWrite),
    .cfgBus    (cfgBus),
    .cfgDev    (cfgDev),
    .cfgFunc   (cfgFunc),
    .cfgReg    (cfgReg),
    .cfgByteEn (cfgByteEn),
    .cfgWdata  (cfgWdata)
  );
endmodule

// File: tb/pci_cfg_port_tb_top.sv
module pci_cfg_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostValid = 1'b0;
  logic        hostWrite = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [1:0]  hostSize = '0;
  logic [31:0] hostWdata = '0;
  logic        hostReady, hostRspValid, cfgReqValid, cfgWrite;
  logic [31:0] hostRdata, cfgWdata;
  logic [7:0]  cfgBus;
  logic [4:0]  cfgDev;
  logic [2:0]  cfgFunc;
  logic [5:0]  cfgReg;
  logic [3:0]  cfgByteEn;
  logic        cfgRspValid = 1'b0;
  logic [31:0] cfgRspData = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_cfg_port dut_i (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWdata(hostWdata),
    .hostReady(hostReady), .hostRspValid(hostRspValid), .hostRdata(hostRdata),
    .cfgReqValid(cfgReqValid), .cfgWrite(cfgWrite), .cfgBus(cfgBus),
    .cfgDev(cfgDev), .cfgFunc(cfgFunc), .cfgReg(cfgReg),
    .cfgByteEn(cfgByteEn), .cfgWdata(cfgWdata),
    .cfgRspValid(cfgRspValid), .cfgRspData(cfgRspData)
  );

  typedef struct {
    logic [31:0] data;
    string       req;
  } hostExp_t;

  typedef struct {
    logic [26:0] hdr;
    logic [31:0] wd;
    string       req;
  } cfgExp_t;

  hostExp_t    hostQ[$];
  cfgExp_t     cfgQ[$];
  int          vectors = 0;
  int          miscompares = 0;
  logic [31:0] addrModel = '0;
  logic [31:0] rspPlan = '0;
  bit          finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] beOf(input logic [1:0] sz, input logic [1:0] off);
    logic [7:0] m;
    m = (sz == 2'd0) ? 8'h01 : (sz == 2'd1) ? 8'h03 : 8'h0F;
    m = m << off;
    return m[3:0];
  endfunction

  // driver: computes expectations from the requirements and pushes them
  task automatic hostAccess(input logic wr, input logic [2:0] off, input logic [1:0] sz,
                            input logic [31:0] wd, input string req);
    hostExp_t he;
    cfgExp_t  ce;
    @(negedge clk);
    while (!hostReady) @(negedge clk);
    he.req = req;
    if (!off[2]) begin
      if (wr) begin
        if (off[1:0] == 2'd0 && sz[1]) addrModel = (wd & 32'hFFFF_FFFC) | 32'h8000_0000;
        he.data = '0;
      end else begin
        he.data = addrModel;
      end
      hostQ.push_back(he);
    end else begin
      ce.hdr = {wr, addrModel[23:16], addrModel[15:11], addrModel[10:8],
                addrModel[7:2], beOf(sz, off[1:0])};
      ce.wd  = wd;
      ce.req = req;
      cfgQ.push_back(ce);
      rspPlan = wr ? (wd ^ 32'h5A5A_0F0F) : wd;
      he.data = wr ? 32'h0 : wd;
      hostQ.push_back(he);
    end
    hostValid = 1'b1; hostWrite = wr; hostAddr = off; hostSize = sz;
    hostWdata = wr ? wd : 32'h0;
    @(negedge clk);
    hostValid = 1'b0;
    if (off[2]) check("R9 ready low while busy", {31'b0, hostReady}, 32'h0);
  endtask

  // monitor: host responses
  always @(negedge clk) begin
    if (rstN && hostRspValid) begin
      if (hostQ.size() == 0) begin
        check("R4 unexpected response", 32'h1, 32'h0);
      end else begin
        hostExp_t e;
        e = hostQ.pop_front();
        check(e.req, hostRdata, e.data);
      end
    end
  end

  // completer model and request monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && cfgReqValid) begin
        if (cfgQ.size() == 0) begin
          check("R7 unexpected request", 32'h1, 32'h0);
        end else begin
          cfgExp_t e;
          e = cfgQ.pop_front();
          check({e.req, " R5 R6 header"},
                {5'b0, cfgWrite, cfgBus, cfgDev, cfgFunc, cfgReg, cfgByteEn},
                {5'b0, e.hdr});
          if (e.hdr[26]) check({e.req, " R7 wdata"}, cfgWdata, e.wd);
        end
        repeat (2) @(negedge clk);
        check("R7 request held", {31'b0, cfgReqValid}, 32'h1);
        cfgRspValid = 1'b1;
        cfgRspData  = rspPlan;
        @(negedge clk);
        cfgRspValid = 1'b0;
        cfgRspData  = '0;
        check("R7 request dropped", {31'b0, cfgReqValid}, 32'h0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 ready", {31'b0, hostReady}, 32'h1);
    check("R1 no request", {31'b0, cfgReqValid}, 32'h0);
    check("R1 no response", {31'b0, hostRspValid}, 32'h0);
    hostAccess(1'b0, 3'd0, 2'd2, 32'h0, "R1 reset address");

    hostAccess(1'b1, 3'd0, 2'd2, 32'h0012_3ABF, "R3 write ack");
    hostAccess(1'b0, 3'd0, 2'd2, 32'h0, "R3 sanitized value");
    hostAccess(1'b0, 3'd2, 2'd1, 32'h0, "R4 read at offset 2");
    hostAccess(1'b0, 3'd3, 2'd0, 32'h0, "R4 read at offset 3");

    hostAccess(1'b1, 3'd0, 2'd1, 32'h0000_FFFF, "R2 narrow write ack");
    hostAccess(1'b0, 3'd0, 2'd2, 32'h0, "R2 after narrow write");
    hostAccess(1'b1, 3'd1, 2'd2, 32'h7777_7777, "R2 misaligned write ack");
    hostAccess(1'b0, 3'd0, 2'd2, 32'h0, "R2 after misaligned write");
    hostAccess(1'b1, 3'd0, 2'd0, 32'h0000_0055, "R2 byte write ack");
    hostAccess(1'b0, 3'd1, 2'd2, 32'h0, "R2 after byte write");

    hostAccess(1'b0, 3'd4, 2'd2, 32'hCAFE_F00D, "R8 data read word");
    hostAccess(1'b1, 3'd4, 2'd2, 32'h1122_3344, "R7 data write word");
    for (int k = 0; k < 4; k++)
      hostAccess(1'b1, 3'(4 + k), 2'd0, 32'hA0 << (8 * k), "R6 byte write lane");
    hostAccess(1'b0, 3'd6, 2'd1, 32'h0BAD_BEEF, "R6 R8 half read upper");
    hostAccess(1'b0, 3'd7, 2'd1, 32'h1357_9BDF, "R6 half read offset 3");
    hostAccess(1'b0, 3'd5, 2'd3, 32'h2468_ACE0, "R6 word code 3 offset 1");

    hostAccess(1'b1, 3'd0, 2'd3, 32'hFFFF_FFFF, "R3 all ones write ack");
    hostAccess(1'b0, 3'd0, 2'd2, 32'h0, "R3 all ones value");
    hostAccess(1'b0, 3'd4, 2'd2, 32'h8765_4321, "R5 max fields read");
    hostAccess(1'b1, 3'd0, 2'd2, 32'h0000_0000, "R3 zero write ack");
    hostAccess(1'b0, 3'd0, 2'd2, 32'h0, "R3 enable forced");
    hostAccess(1'b1, 3'd4, 2'd1, 32'h0000_ABCD, "R5 zero fields write");
    hostAccess(1'b1, 3'd0, 2'd2, 32'h00A5_5A48, "R3 mixed write ack");
    hostAccess(1'b0, 3'd4, 2'd0, 32'h0000_00EE, "R5 mixed fields read");

    repeat (12) @(negedge clk);
    check("R7 all responses seen", hostQ.size(), 32'h0);
    check("R7 all requests seen", cfgQ.size(), 32'h0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule